// File: doc/BRIEF.md
# Two-Stage Segmented CAM Search

This block is a clocked content-addressable memory whose stored words are split into two segments. The short low segment, the last k bits of each word, is compared against the search key in every entry first. Only the entries that agree on that segment go on to compare the long high segment, the first n-k bits. Every other entry stays idle in the second stage, which keeps comparator activity low because most mismatches are resolved by the few low bits.

Words are loaded through a write port with an address, data and an enable. A search key presented with a valid strobe passes through two registered stages. The block then returns a done pulse, a hit flag and the binary index of the matching entry. A write always takes the cycle it is issued in, so a search strobe in that same cycle is dropped. A search is judged against the table as it stood when the search was issued.

Top module: `seg_cam_top`

## Requirements
- R1: While reset is held and directly after it, done_o, hit_o and match_addr_o are all 0 and every entry is empty.
- R2: A word written at address A, searched at least one cycle after the write, returns hit_o=1 with match_addr_o=A.
- R3: When wr_en_i and search_valid_i are high in the same cycle, the write is performed and the search is discarded: no done pulse is produced for it.
- R4: An accepted search, meaning search_valid_i high while wr_en_i is low before clock edge E, produces done_o=1 in the cycle after edge E+1 for exactly that one cycle. Searches accepted on consecutive cycles give done pulses on consecutive cycles, in the order the searches were issued.
- R5: An entry matches only if both segments agree. The low segment is bits [k-1:0] and the high segment is bits [n-1:k]. Agreement in only one segment is a miss.
- R6: When several valid entries hold the key, match_addr_o reports the lowest index.
- R7: A search with no matching entry still gives done_o=1, with hit_o=0 and match_addr_o=0.
- R8: An entry that has never been written never matches, even for a key equal to its reset contents (all zeros).
- R9: A search sees the table as it was when the search was issued. A write in the cycle after the search does not change that search's result.
- R10: In every cycle where done_o is 0, hit_o and match_addr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe; takes precedence over a search |
| wr_addr_i | input | $clog2(DEPTH) | Entry index to write |
| wr_data_i | input | WORD_W | Word to store |
| search_valid_i | input | 1 | Search strobe |
| search_word_i | input | WORD_W | Search key |
| done_o | output | 1 | One-cycle result strobe, two edges after an accepted search |
| hit_o | output | 1 | At least one entry matched |
| match_addr_o | output | $clog2(DEPTH) | Lowest matching index, 0 on a miss |

## Verification
Two functions can meet in one cycle: a write and a search. The bench raises both strobes together and checks that the write lands but no result appears for that search. It also issues a write in the cycle just after a search, while that search sits in its second stage, and checks that the result reflects the old contents. A behavioural table in the bench predicts done, hit and address for every cycle, so a lost, duplicated or stale result shows up as a mismatch on that cycle.

// File: rtl/seg_cam_pkg.sv
package seg_cam_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_SEG_W  = 4;
  localparam int unsigned DEF_DEPTH  = 16;
endpackage

// File: rtl/seg_cam_store.sv
module seg_cam_store #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned HI_W  = WORD_W - SEG_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [AW-1:0]               wr_addr_i,
  input  logic [WORD_W-1:0]           wr_data_i,
  output logic [DEPTH-1:0]            valid_o,
  output logic [DEPTH-1:0][SEG_W-1:0] lo_o,
  output logic [DEPTH-1:0][HI_W-1:0]  hi_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        lo_o[i]    <= '0;
        hi_o[i]    <= '0;
      end else if (wr_en_i && wr_addr_i == AW'(i)) begin
        valid_o[i] <= 1'b1;
        lo_o[i]    <= wr_data_i[SEG_W-1:0];
        hi_o[i]    <= wr_data_i[WORD_W-1:SEG_W];
      end
    end
  end
endmodule

// File: rtl/seg_cam_stage1.sv
module seg_cam_stage1 #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned HI_W  = WORD_W - SEG_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        go_i,
  input  logic [WORD_W-1:0]           key_i,
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0][SEG_W-1:0] lo_i,
  output logic                        s1_valid_o,
  output logic [DEPTH-1:0]            s1_hit_o,
  output logic [HI_W-1:0]             s1_key_hi_o
);
  logic [DEPTH-1:0] lo_eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign lo_eq[i] = valid_i[i] && (lo_i[i] == key_i[SEG_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_o  <= 1'b0;
      s1_hit_o    <= '0;
      s1_key_hi_o <= '0;
    end else begin
      s1_valid_o <= go_i;
      s1_hit_o   <= go_i ? lo_eq : '0;
      if (go_i) s1_key_hi_o <= key_i[WORD_W-1:SEG_W];
    end
  end

  // R8
  empty_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_hit_o & ~$past(valid_i)) == '0);
endmodule

// File: rtl/seg_cam_stage2.sv
module seg_cam_stage2 #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned HI_W  = WORD_W - SEG_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       s1_valid_i,
  input  logic [DEPTH-1:0]           s1_hit_i,
  input  logic [HI_W-1:0]            s1_key_hi_i,
  input  logic [DEPTH-1:0][HI_W-1:0] hi_i,
  output logic                       s2_valid_o,
  output logic [DEPTH-1:0]           s2_match_o
);
  logic [DEPTH-1:0] full_eq;

  // only entries enabled by the first stage evaluate the wide segment
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign full_eq[i] = s1_hit_i[i] ? (hi_i[i] == s1_key_hi_i) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid_o <= 1'b0;
      s2_match_o <= '0;
    end else begin
      s2_valid_o <= s1_valid_i;
      s2_match_o <= s1_valid_i ? full_eq : '0;
    end
  end

  // R5
  gated_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_match_o & ~$past(s1_hit_i)) == '0);
endmodule

// File: rtl/seg_cam_prio_enc.sv
module seg_cam_prio_enc #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] match_i,
  output logic             hit_o,
  output logic [AW-1:0]    idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        idx_o = AW'(i);
      end
    end
  end
endmodule

// File: rtl/seg_cam_top.sv
module seg_cam_top
  import seg_cam_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned SEG_W  = DEF_SEG_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned HI_W  = WORD_W - SEG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              search_valid_i,
  input  logic [WORD_W-1:0] search_word_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [AW-1:0]     match_addr_o
);
  logic                        go;
  logic [DEPTH-1:0]            valid;
  logic [DEPTH-1:0][SEG_W-1:0] lo;
  logic [DEPTH-1:0][HI_W-1:0]  hi;
  logic                        s1_valid;
  logic [DEPTH-1:0]            s1_hit;
  logic [HI_W-1:0]             s1_key_hi;
  logic [DEPTH-1:0]            s2_match;

  // write owns the cycle
  assign go = search_valid_i && !wr_en_i;

  seg_cam_store #(.WORD_W(WORD_W), .SEG_W(SEG_W), .DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .valid_o(valid), .lo_o(lo), .hi_o(hi)
  );

  seg_cam_stage1 #(.WORD_W(WORD_W), .SEG_W(SEG_W), .DEPTH(DEPTH)) i_stage1 (
    .clk_i, .rst_ni, .go_i(go), .key_i(search_word_i), .valid_i(valid), .lo_i(lo),
    .s1_valid_o(s1_valid), .s1_hit_o(s1_hit), .s1_key_hi_o(s1_key_hi)
  );

  seg_cam_stage2 #(.WORD_W(WORD_W), .SEG_W(SEG_W), .DEPTH(DEPTH)) i_stage2 (
    .clk_i, .rst_ni, .s1_valid_i(s1_valid), .s1_hit_i(s1_hit), .s1_key_hi_i(s1_key_hi),
    .hi_i(hi), .s2_valid_o(done_o), .s2_match_o(s2_match)
  );

  seg_cam_prio_enc #(.DEPTH(DEPTH)) i_enc (
    .match_i(s2_match), .hit_o(hit_o), .idx_o(match_addr_o)
  );

  // R3
  write_blocks_search_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !s1_valid);
  // R4
  done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> done_o);
  // R4
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> !done_o);
  // R6
  lowest_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> s2_match[match_addr_o] &&
              ((s2_match & ((DEPTH'(1) << match_addr_o) - DEPTH'(1))) == '0));
  // R10
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !hit_o && match_addr_o == '0);
endmodule

// File: tb/test_seg_cam_top.sv
module test_seg_cam_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 16;
  localparam int AW     = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [AW-1:0]     wr_addr_i = '0;
  logic [WORD_W-1:0] wr_data_i = '0;
  logic              search_valid_i = 1'b0;
  logic [WORD_W-1:0] search_word_i = '0;
  logic              done_o, hit_o;
  logic [AW-1:0]     match_addr_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [WORD_W-1:0] m_word [DEPTH];
  bit                m_vld  [DEPTH];
  bit pend_done, pend_hit, exp_done, exp_hit;
  int pend_addr, exp_addr;

  seg_cam_top i_seg_cam_top (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check_out();
    checks++;
    if (done_o !== exp_done || hit_o !== exp_hit || int'(match_addr_o) != exp_addr) begin
      errors++;
      $display("FAIL %s: done/hit/addr = %0b/%0b/%0d, expected %0b/%0b/%0d",
               cur_req, done_o, hit_o, match_addr_o, exp_done, exp_hit, exp_addr);
    end
  endtask

  task automatic step(input bit we, input int wa, input logic [WORD_W-1:0] wd,
                      input bit sv, input logic [WORD_W-1:0] sw);
    bit nh;
    int na;
    wr_en_i = we; wr_addr_i = AW'(wa); wr_data_i = wd;
    search_valid_i = sv; search_word_i = sw;
    @(posedge clk_i);
    exp_done = pend_done; exp_hit = pend_hit; exp_addr = pend_addr;
    nh = 1'b0; na = 0;
    if (sv && !we)
      for (int i = DEPTH - 1; i >= 0; i--)
        if (m_vld[i] && m_word[i] == sw) begin nh = 1'b1; na = i; end
    pend_done = sv && !we; pend_hit = nh; pend_addr = na;
    if (we) begin m_word[wa] = wd; m_vld[wa] = 1'b1; end
    @(negedge clk_i);
    check_out();
  endtask

  task automatic wr(input int a, input logic [WORD_W-1:0] d);
    step(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic srch(input logic [WORD_W-1:0] k);
    step(1'b0, 0, '0, 1'b1, k);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, '0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_word[i] = '0; m_vld[i] = 1'b0; end
    pend_done = 0; pend_hit = 0; pend_addr = 0;
    exp_done = 0; exp_hit = 0; exp_addr = 0;
    repeat (2) @(negedge clk_i);
    cur_req = "R1";
    check_out();
    rst_ni = 1'b1;
    idle(2);

    cur_req = "R8/R7";       // empty table, key equal to reset contents
    srch(16'h0000); idle(2);

    cur_req = "R2";
    wr(3, 16'h1234); wr(5, 16'hABC4); wr(7, 16'h1235);
    wr(9, 16'h1234); wr(2, 16'h5678);
    srch(16'h5678); idle(2);

    cur_req = "R6";          // entries 3 and 9 both hold the key
    srch(16'h1234); idle(2);

    cur_req = "R5";          // one segment agrees, the other does not
    srch(16'h1230); srch(16'hFFF4); srch(16'h1236); idle(2);

    cur_req = "R4";          // back-to-back results, in order
    srch(16'hABC4); srch(16'h1235); srch(16'h0BAD); srch(16'h1234); idle(3);

    cur_req = "R3";          // write and search in the same cycle
    step(1'b1, 2, 16'h9999, 1'b1, 16'h5678); idle(2);
    srch(16'h5678); srch(16'h9999); idle(2);

    cur_req = "R9";          // write lands while search is in stage two
    srch(16'h9999); wr(2, 16'h1111); idle(2);
    srch(16'h1111); idle(2);

    cur_req = "R6";          // lowest duplicate overwritten
    wr(3, 16'h0000); srch(16'h1234); idle(2);
    cur_req = "R8";          // written zero now matches at 3
    srch(16'h0000); idle(2);

    cur_req = "R2";          // boundary indices
    wr(0, 16'hFFFF); wr(15, 16'h8001);
    srch(16'hFFFF); srch(16'h8001); idle(2);

    cur_req = "R10";
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule